// File: doc/BRIEF.md
# Register Redirection Table

This block translates the 5-bit architectural register numbers of a decoded instruction into 6-bit physical register numbers. It also returns the per-register attributes that steer the vector loop: whether the register is a vector, an element-width override code, and whether elements are packed SIMD-style. The integer and floating-point register files each have a table of their own. Each lookup port picks a table with a file-select bit, so one instruction can mix both files.

Entries are installed through a single configuration write port. Each write names a source register, the redirected target, a bank bit and the three attributes. Bank 1 is reserved. A write that asks for it is refused and a one-cycle error strobe is raised. Registers without an entry pass straight through as scalars in bank 0. Lookup is combinational: two source ports and one destination port translate a whole instruction in the same cycle its register fields arrive.

Top module: `redir_table`

## Requirements
- R1: After reset, both tables are empty, and every lookup port returns physical index {0, register}, vector flag 0, width code 0 and SIMD flag 0.
- R2: An accepted write is visible on any lookup port from the cycle after the write edge. A lookup of that source register in the same file returns {0, target}, together with the written vector flag, the 2-bit width code (0 = keep the operation's own width, 1 to 3 = override) and the SIMD flag.
- R3: File select 0 addresses the integer table and 1 addresses the floating-point table. A write to one file never changes a lookup result of the other file.
- R4: A register with no entry in the selected table passes through as {0, register} with vector 0, width 0 and SIMD 0.
- R5: A write to a source register that already has an entry in that file replaces the entry and uses no extra slot.
- R6: A write with bank bit 1 is refused. The table keeps its contents, and the error output is high in the cycle after the write edge.
- R7: Each file holds at most 16 distinct source registers. A write of a new source register to a full table is refused, the table keeps its contents, and the error output is high in the cycle after the write edge.
- R8: The three lookup ports work independently and combinationally. Each port's result follows its own file select and register in the same cycle. The physical index's top (bank) bit is always 0.
- R9: The error output is high only in the cycle after a refused write. After an accepted write, or when no write occurs, it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_file_i | input | 1 | Target table of the write: 0 integer, 1 floating point |
| cfg_src_i | input | 5 | Architectural register being redirected |
| cfg_tgt_i | input | 5 | Redirected register index |
| cfg_bank_i | input | 1 | Bank bit of the target; 1 is reserved |
| cfg_vec_i | input | 1 | Vector flag |
| cfg_width_i | input | 2 | Width override code, 0 = no override |
| cfg_simd_i | input | 1 | Packed SIMD element flag |
| cfg_err_o | output | 1 | One-cycle strobe for a refused write |
| lk_file_i | input | 3 | Per-port file select (ports 0,1 sources, port 2 destination) |
| lk_reg_i | input | 3x5 | Per-port architectural register |
| lk_phys_o | output | 3x6 | Per-port physical index {bank, index} |
| lk_vec_o | output | 3 | Per-port vector flag |
| lk_width_o | output | 3x2 | Per-port width code |
| lk_simd_o | output | 3 | Per-port SIMD flag |

## Verification
A corrupted entry, a lost valid bit or a wrong slot choice does not stay hidden. It shows on the next lookup of the affected register, in the same cycle that register is presented, as a wrong target or attribute. A slot-count fault shows only as a refusal that comes too early or too late. So the table is filled to exactly its capacity and then overrun by one. Errors in the refusal path show one cycle after the faulty write, on the error strobe.

// File: rtl/redir_pkg.sv
package redir_pkg;
  localparam int REG_W = 5;
  localparam int WID_W = 2;
  localparam int NUM_FILES = 2;

  typedef struct packed {
    logic             valid;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] tgt;
    logic             vec;
    logic [WID_W-1:0] width;
    logic             simd;
  } redir_entry_t;
endpackage

// File: rtl/redir_bank_store.sv
module redir_bank_store
  import redir_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_i,
  input  logic                              we_i,
  input  logic [REG_W-1:0]                  src_i,
  input  logic [REG_W-1:0]                  tgt_i,
  input  logic                              bank_i,
  input  logic                              vec_i,
  input  logic [WID_W-1:0]                  width_i,
  input  logic                              simd_i,
  output redir_entry_t [NUM_ENTRIES-1:0]    entries_o,
  output logic                              reject_o
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  redir_entry_t [NUM_ENTRIES-1:0] slots_q;
  logic             hit_found, free_found;
  logic [IDX_W-1:0] hit_idx, free_idx, wr_idx;

  always_comb begin
    hit_found  = 1'b0;
    free_found = 1'b0;
    hit_idx    = '0;
    free_idx   = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!hit_found && slots_q[i].valid && slots_q[i].src == src_i) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(i);
      end
      if (!free_found && !slots_q[i].valid) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign wr_idx   = hit_found ? hit_idx : free_idx;
  assign reject_o = bank_i | (!hit_found & !free_found);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      slots_q <= '0;
    end else if (we_i && !reject_o) begin
      slots_q[wr_idx] <= '{valid: 1'b1, src: src_i, tgt: tgt_i,
                           vec: vec_i, width: width_i, simd: simd_i};
    end
  end

  assign entries_o = slots_q;
endmodule

// File: rtl/redir_port_lookup.sv
module redir_port_lookup
  import redir_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  redir_entry_t [NUM_ENTRIES-1:0] entries_i,
  input  logic [REG_W-1:0]               reg_i,
  output logic [REG_W:0]                 phys_o,
  output logic                           vec_o,
  output logic [WID_W-1:0]               width_o,
  output logic                           simd_o
);
  logic             hit;
  logic [REG_W-1:0] tgt;
  logic             vec, simd;
  logic [WID_W-1:0] width;

  always_comb begin
    hit   = 1'b0;
    tgt   = '0;
    vec   = 1'b0;
    width = '0;
    simd  = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!hit && entries_i[i].valid && entries_i[i].src == reg_i) begin
        hit   = 1'b1;
        tgt   = entries_i[i].tgt;
        vec   = entries_i[i].vec;
        width = entries_i[i].width;
        simd  = entries_i[i].simd;
      end
    end
  end

  assign phys_o  = {1'b0, hit ? tgt : reg_i};
  assign vec_o   = vec;
  assign width_o = width;
  assign simd_o  = simd;
endmodule

// File: rtl/redir_table.sv
module redir_table
  import redir_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 3
) (
  input  logic                                 clk_i,
  input  logic                                 rst_i,
  input  logic                                 cfg_we_i,
  input  logic                                 cfg_file_i,
  input  logic [REG_W-1:0]                     cfg_src_i,
  input  logic [REG_W-1:0]                     cfg_tgt_i,
  input  logic                                 cfg_bank_i,
  input  logic                                 cfg_vec_i,
  input  logic [WID_W-1:0]                     cfg_width_i,
  input  logic                                 cfg_simd_i,
  output logic                                 cfg_err_o,
  input  logic [NUM_PORTS-1:0]                 lk_file_i,
  input  logic [NUM_PORTS-1:0][REG_W-1:0]      lk_reg_i,
  output logic [NUM_PORTS-1:0][REG_W:0]        lk_phys_o,
  output logic [NUM_PORTS-1:0]                 lk_vec_o,
  output logic [NUM_PORTS-1:0][WID_W-1:0]      lk_width_o,
  output logic [NUM_PORTS-1:0]                 lk_simd_o
);
  redir_entry_t [NUM_FILES-1:0][NUM_ENTRIES-1:0] file_entries;
  logic [NUM_FILES-1:0] file_reject;
  logic                 err_q;

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    redir_bank_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .we_i      (cfg_we_i && (cfg_file_i == f[0])),
      .src_i     (cfg_src_i),
      .tgt_i     (cfg_tgt_i),
      .bank_i    (cfg_bank_i),
      .vec_i     (cfg_vec_i),
      .width_i   (cfg_width_i),
      .simd_i    (cfg_simd_i),
      .entries_o (file_entries[f]),
      .reject_o  (file_reject[f])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    redir_port_lookup #(.NUM_ENTRIES(NUM_ENTRIES)) u_lookup (
      .entries_i (file_entries[lk_file_i[p]]),
      .reg_i     (lk_reg_i[p]),
      .phys_o    (lk_phys_o[p]),
      .vec_o     (lk_vec_o[p]),
      .width_o   (lk_width_o[p]),
      .simd_o    (lk_simd_o[p])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) err_q <= 1'b0;
    else       err_q <= cfg_we_i & file_reject[cfg_file_i];
  end

  assign cfg_err_o = err_q;
endmodule

// File: rtl/redir_table_chk.sv
module redir_table_chk
  import redir_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input logic                            clk_i,
  input logic                            rst_i,
  input logic                            cfg_we_i,
  input logic                            cfg_file_i,
  input logic [REG_W-1:0]                cfg_src_i,
  input logic [REG_W-1:0]                cfg_tgt_i,
  input logic                            cfg_bank_i,
  input logic                            cfg_err_o,
  input logic [NUM_PORTS-1:0]            lk_file_i,
  input logic [NUM_PORTS-1:0][REG_W-1:0] lk_reg_i,
  input logic [NUM_PORTS-1:0][REG_W:0]   lk_phys_o,
  input logic [NUM_PORTS-1:0]            lk_vec_o,
  input logic [NUM_PORTS-1:0][WID_W-1:0] lk_width_o,
  input logic [NUM_PORTS-1:0]            lk_simd_o
);
  AST_BANK_REFUSED: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg_we_i && cfg_bank_i |=> cfg_err_o); // R6

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    !cfg_we_i |=> !cfg_err_o); // R9

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    AST_WRITE_VISIBLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (cfg_we_i && !cfg_bank_i) |=>
        (cfg_err_o || lk_file_i[p] != $past(cfg_file_i) || lk_reg_i[p] != $past(cfg_src_i)
         || lk_phys_o[p] == {1'b0, $past(cfg_tgt_i)})); // R2

    AST_OTHER_FILE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && (!$past(cfg_we_i) || $past(cfg_file_i) != lk_file_i[p])
       && $stable(lk_file_i[p]) && $stable(lk_reg_i[p])) |->
        ($stable(lk_phys_o[p]) && $stable(lk_vec_o[p]) && $stable(lk_width_o[p])
         && $stable(lk_simd_o[p]))); // R3
  end
endmodule

bind redir_table redir_table_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .cfg_we_i(cfg_we_i), .cfg_file_i(cfg_file_i),
  .cfg_src_i(cfg_src_i), .cfg_tgt_i(cfg_tgt_i), .cfg_bank_i(cfg_bank_i),
  .cfg_err_o(cfg_err_o), .lk_file_i(lk_file_i), .lk_reg_i(lk_reg_i),
  .lk_phys_o(lk_phys_o), .lk_vec_o(lk_vec_o), .lk_width_o(lk_width_o),
  .lk_simd_o(lk_simd_o)
);

// File: tb/redir_table_tb.sv
module redir_table_tb;
  localparam int NP = 3;
  localparam int CAP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0, wfile = 1'b0, wbank = 1'b0, wvec = 1'b0, wsimd = 1'b0;
  logic [4:0] wsrc = '0, wtgt = '0;
  logic [1:0] wwidth = '0;
  logic err;
  logic [NP-1:0] lfile = '0;
  logic [NP-1:0][4:0] lreg = '0;
  logic [NP-1:0][5:0] lphys;
  logic [NP-1:0] lvec, lsimd;
  logic [NP-1:0][1:0] lwidth;

  always #10 clk = ~clk;

  redir_table u_dut (
    .clk_i(clk), .rst_i(rst), .cfg_we_i(we), .cfg_file_i(wfile), .cfg_src_i(wsrc),
    .cfg_tgt_i(wtgt), .cfg_bank_i(wbank), .cfg_vec_i(wvec), .cfg_width_i(wwidth),
    .cfg_simd_i(wsimd), .cfg_err_o(err), .lk_file_i(lfile), .lk_reg_i(lreg),
    .lk_phys_o(lphys), .lk_vec_o(lvec), .lk_width_o(lwidth), .lk_simd_o(lsimd)
  );

  // reference model indexed by architectural register
  bit       m_on [2][32];
  int       m_tgt[2][32];
  bit       m_vec[2][32];
  int       m_wid[2][32];
  bit       m_smd[2][32];
  int       m_cnt[2];
  bit       m_err;
  int       checks = 0, errors = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    for (int p = 0; p < NP; p++) begin
      int f = lfile[p];
      int r = lreg[p];
      chk(req, $sformatf("port%0d phys", p), lphys[p], m_on[f][r] ? m_tgt[f][r] : r);
      chk(req, $sformatf("port%0d vec", p), lvec[p], m_on[f][r] ? m_vec[f][r] : 0);
      chk(req, $sformatf("port%0d width", p), lwidth[p], m_on[f][r] ? m_wid[f][r] : 0);
      chk(req, $sformatf("port%0d simd", p), lsimd[p], m_on[f][r] ? m_smd[f][r] : 0);
    end
    chk(req, "err", err, m_err);
  endtask

  task automatic step(string req);
    #2;
    if (!rst) compare(req);
    @(posedge clk);
    if (rst) begin
      foreach (m_on[f, r]) m_on[f][r] = 0;
      m_cnt = '{0, 0};
      m_err = 0;
    end else if (we) begin
      int f = wfile;
      int s = wsrc;
      if (wbank) m_err = 1;
      else if (!m_on[f][s] && m_cnt[f] >= CAP) m_err = 1;
      else begin
        m_err = 0;
        if (!m_on[f][s]) m_cnt[f]++;
        m_on[f][s] = 1; m_tgt[f][s] = wtgt; m_vec[f][s] = wvec;
        m_wid[f][s] = wwidth; m_smd[f][s] = wsimd;
      end
    end else m_err = 0;
    @(negedge clk);
  endtask

  task automatic wr(bit f, int s, int t, bit b, bit v, int w, bit sm);
    we = 1; wfile = f; wsrc = 5'(s); wtgt = 5'(t); wbank = b;
    wvec = v; wwidth = 2'(w); wsimd = sm;
  endtask

  task automatic look(int p, bit f, int r);
    lfile[p] = f; lreg[p] = 5'(r);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) step("R1");
    rst = 0;
    // R1: empty tables after reset
    look(0, 0, 7); look(1, 1, 31); look(2, 0, 0);
    step("R1");
    // R2: install int mapping 3 -> 17
    wr(0, 3, 17, 0, 1, 2, 1); step("R2");
    we = 0; look(0, 0, 3); look(1, 1, 3); look(2, 0, 4);
    step("R2");  // R3 on port1, R4 on port2
    // R3: fp write must not affect int lookup of 3
    wr(1, 3, 9, 0, 0, 3, 0); step("R3");
    we = 0; step("R3");
    // R6: bank 1 refused
    wr(0, 3, 30, 1, 0, 1, 0); step("R6");
    we = 0; step("R6");
    step("R9");
    // R5: replace entry for 3
    wr(0, 3, 21, 0, 0, 1, 0); step("R5");
    we = 0; step("R5");
    // R7: fill int table to capacity with srcs 4..18
    for (int s = 4; s <= 18; s++) begin
      wr(0, s, 31 - s, 0, s[0], s % 4, s[1]); look(2, 0, s); step("R7");
    end
    wr(0, 19, 1, 0, 1, 1, 1); look(0, 0, 19); step("R7");
    we = 0; look(1, 0, 18); step("R7");
    wr(0, 5, 2, 0, 1, 3, 1); look(2, 0, 5); step("R5");
    we = 0; step("R5");
    // R8: random traffic, ports independent
    for (int n = 0; n < 400; n++) begin
      we = ($urandom % 2) == 0; wfile = 1'($urandom); wsrc = 5'($urandom);
      wtgt = 5'($urandom); wbank = ($urandom % 8) == 0; wvec = 1'($urandom);
      wwidth = 2'($urandom); wsimd = 1'($urandom);
      for (int p = 0; p < NP; p++) look(p, 1'($urandom), 5'($urandom));
      step("R8");
    end
    we = 0; step("R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule